// File: doc/BRIEF.md
# Modem Handshake Control and Status Unit

This unit sits beside the data path of a serial controller and handles its modem handshake lines. The three incoming lines (clear-to-send, data-set-ready and carrier-detect) are brought into the controller clock domain by a synchronizer chain. Each line's present level is reported, and a sticky flag is set whenever the synchronized level changes. Software clears a flag by writing a one to its bit in the status register. Each flag has its own interrupt enable, and all enabled flags are ORed into a single interrupt request.

The two outgoing handshake lines (request-to-send and data-terminal-ready) follow bits in a control register. The same register selects two diagnostic routings of the serial data path. Echo mode sends the received line straight back out on the transmit pin. Test mode feeds the transmitter's output back into the receiver and holds the transmit pin at the idle mark level. Registers are reached through a small flat port: an address, a write strobe, write data and read data that is always valid. Character framing is handled elsewhere.

Top module: `mdm_ctl_top`

## Requirements
- R1: After reset every register reads zero, and rts_out, dtr_out and irq are low.
- R2: Status bits 4, 3 and 2 (address 0) show the CTS, DSR and DCD levels. A change on an input pin becomes visible after two rising clock edges.
- R3: Status bits 7, 6 and 5 are the CTS, DSR and DCD transition flags. A flag is set on the edge after its level bit changes and then stays set.
- R4: Writing address 0 with a 1 in bit 7, 6 or 5 clears that flag. Zeros in those bits have no effect, and the level bits and bits 1:0 cannot be written.
- R5: When a flag is being cleared in the same cycle that a new transition on its line is detected, the flag ends up set.
- R6: Control register (address 1) bit 7 drives rts_out and bit 6 drives dtr_out. Bits 7, 6, 2 and 1 read back as written, and the other bits read 0.
- R7: The enable register (address 2) keeps bits 7, 6 and 5 (CTS, DSR, DCD), and its other bits read 0. Address 3 always reads 0.
- R8: irq is high exactly when at least one transition flag and its matching enable bit are both set. It is a combinational function of those registers.
- R9: With control bit 2 set and bit 1 clear (echo), line_tx_pin follows line_rx_pin and core_rx_bit follows line_rx_pin.
- R10: With control bit 1 set (test), core_rx_bit follows core_tx_bit and line_tx_pin is held at 1, whatever the value of bit 2.
- R11: With control bits 2 and 1 both clear, line_tx_pin follows core_tx_bit and core_rx_bit follows line_rx_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (2) | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for reg_addr |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| rts_out | output | 1 | Request-to-send line |
| dtr_out | output | 1 | Data-terminal-ready line |
| irq | output | 1 | Interrupt request |
| line_rx_pin | input | 1 | Serial receive pin |
| line_tx_pin | output | 1 | Serial transmit pin |
| core_tx_bit | input | 1 | Bit from the transmitter |
| core_rx_bit | output | 1 | Bit to the receiver |

## Verification
The bench concentrates on the cycle where a write-one clear meets a freshly detected transition. It sweeps the clear across several offsets from the input change. A design that let the clear win would lose an event and drop its interrupt. It also checks that written zeros and writes to the level bits leave the flags untouched, and that a line toggling back and forth sets its flag again after a clear. It drives echo and test both together to confirm that test wins. A wrong priority there would show up as receive data on the transmit pin. Randomized pin activity together with random register traffic catches synchronizer depth errors, because a stage too many or too few moves the level and flag bits by one cycle against the model.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int LINE_CNT  = 3;
   localparam int IDX_DCD   = 0;
   localparam int IDX_DSR   = 1;
   localparam int IDX_CTS   = 2;
   localparam int FLAG_LSB  = 5;
   localparam int LEVEL_LSB = 2;
   localparam int CTL_RTS   = 7;
   localparam int CTL_DTR   = 6;
   localparam int CTL_ECHO  = 2;
   localparam int CTL_TEST  = 1;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_ENABLE = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic rts;
      logic dtr;
      logic echo;
      logic test;
   } ctrl_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mdm_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdm_edge_flag.sv
module mdm_edge_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic clr,
   output logic flag
);
   logic prev;
   logic set;

   assign set = sample ^ prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= 1'b0;
         flag <= 1'b0;
      end else begin
         prev <= sample;
         flag <= set | (flag & ~clr);
      end
   end

   assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && $stable(sample)) |=> !flag);
   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !$stable(sample)) |=> flag);
endmodule

// File: rtl/mdm_loop.sv
module mdm_loop #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic echo_en,
   input  logic test_en,
   input  logic line_rx,
   input  logic core_tx,
   output logic line_tx,
   output logic core_rx
);
   always_comb begin
      if (test_en) begin
         line_tx = IDLE_LVL;
         core_rx = core_tx;
      end else if (echo_en) begin
         line_tx = line_rx;
         core_rx = line_rx;
      end else begin
         line_tx = core_tx;
         core_rx = line_rx;
      end
   end

   assert_test_loop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      test_en |-> (line_tx == IDLE_LVL && core_rx == core_tx));
   assert_echo_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (echo_en && !test_en) |-> (line_tx == line_rx));
endmodule

// File: rtl/mdm_ctl_top.sv
module mdm_ctl_top #(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cts_in,
   input  logic              dsr_in,
   input  logic              dcd_in,
   output logic              rts_out,
   output logic              dtr_out,
   output logic              irq,
   input  logic              line_rx_pin,
   output logic              line_tx_pin,
   input  logic              core_tx_bit,
   output logic              core_rx_bit
);
   import mdm_pkg::*;

   localparam int FLAG_MSB  = FLAG_LSB + LINE_CNT - 1;
   localparam int LEVEL_MSB = LEVEL_LSB + LINE_CNT - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("mdm_ctl_top needs ADDR_W of at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("mdm_ctl_top needs DATA_W of at least 8");
      end
   endgenerate

   // address decode: upper address bits, when present, must be zero
   reg_sel_e sel;
   logic     in_range;
   generate
      if (ADDR_W == 2) begin : g_addr_exact
         assign in_range = 1'b1;
      end else begin : g_addr_wide
         assign in_range = ~|reg_addr[ADDR_W-1:2];
      end
   endgenerate
   assign sel = in_range ? reg_sel_e'(reg_addr[1:0]) : SEL_NONE;

   logic [LINE_CNT-1:0] pins;
   logic [LINE_CNT-1:0] levels;
   logic [LINE_CNT-1:0] flags;
   logic [LINE_CNT-1:0] clr_vec;
   logic [LINE_CNT-1:0] enables;
   ctrl_t               ctrl;

   assign pins[IDX_CTS] = cts_in;
   assign pins[IDX_DSR] = dsr_in;
   assign pins[IDX_DCD] = dcd_in;

   assign clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata[FLAG_MSB:FLAG_LSB]
                                                   : '0;

   for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
      mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
         .clk (clk),
         .rst_n (rst_n),
         .din (pins[i]),
         .dout (levels[i])
      );
      mdm_edge_flag u_flag (
         .clk (clk),
         .rst_n (rst_n),
         .sample (levels[i]),
         .clr (clr_vec[i]),
         .flag (flags[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         enables <= '0;
      end else if (reg_wr) begin
         if (sel == SEL_CTRL) begin
            ctrl.rts  <= reg_wdata[CTL_RTS];
            ctrl.dtr  <= reg_wdata[CTL_DTR];
            ctrl.echo <= reg_wdata[CTL_ECHO];
            ctrl.test <= reg_wdata[CTL_TEST];
         end
         if (sel == SEL_ENABLE) enables <= reg_wdata[FLAG_MSB:FLAG_LSB];
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_STATUS: begin
            reg_rdata[FLAG_MSB:FLAG_LSB]   = flags;
            reg_rdata[LEVEL_MSB:LEVEL_LSB] = levels;
         end
         SEL_CTRL: begin
            reg_rdata[CTL_RTS]  = ctrl.rts;
            reg_rdata[CTL_DTR]  = ctrl.dtr;
            reg_rdata[CTL_ECHO] = ctrl.echo;
            reg_rdata[CTL_TEST] = ctrl.test;
         end
         SEL_ENABLE: reg_rdata[FLAG_MSB:FLAG_LSB] = enables;
         default:    reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata};

   assign rts_out = ctrl.rts;
   assign dtr_out = ctrl.dtr;
   assign irq     = |(flags & enables);

   mdm_loop #(.IDLE_LVL(1'b1)) u_loop (
      .clk (clk),
      .rst_n (rst_n),
      .echo_en (ctrl.echo),
      .test_en (ctrl.test),
      .line_rx (line_rx_pin),
      .core_tx (core_tx_bit),
      .line_tx (line_tx_pin),
      .core_rx (core_rx_bit)
   );

   assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enables == '0) |-> !irq);
   assert_rts_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_CTRL) |=> (rts_out == $past(reg_wdata[CTL_RTS])));
endmodule

// File: tb/mdm_ctl_top_test.sv
module mdm_ctl_top_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0;
   logic       rts_out, dtr_out, irq;
   logic       line_rx_pin = 1'b1, core_tx_bit = 1'b1;
   logic       line_tx_pin, core_rx_bit;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mdm_ctl_top uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in),
      .rts_out(rts_out), .dtr_out(dtr_out), .irq(irq),
      .line_rx_pin(line_rx_pin), .line_tx_pin(line_tx_pin),
      .core_tx_bit(core_tx_bit), .core_rx_bit(core_rx_bit)
   );

   // reference model: history of pin samples, newest first
   logic [2:0] hist[$];
   logic [2:0] m_flag;
   logic [2:0] m_en;
   logic       m_rts, m_dtr, m_echo, m_test;

   initial begin
      hist = '{3'b000, 3'b000, 3'b000};
      m_flag = 0; m_en = 0; m_rts = 0; m_dtr = 0; m_echo = 0; m_test = 0;
   end

   always @(posedge clk) begin
      logic [2:0] newest;
      logic [2:0] chg;
      newest = {cts_in, dsr_in, dcd_in};
      if (!rst_n) begin
         hist = '{3'b000, 3'b000, 3'b000};
         m_flag = 0; m_en = 0; m_rts = 0; m_dtr = 0; m_echo = 0; m_test = 0;
      end else begin
         chg = hist[1] ^ hist[2];
         if (reg_wr && reg_addr == 2'd0) m_flag = m_flag & ~reg_wdata[7:5];
         m_flag = m_flag | chg;
         if (reg_wr && reg_addr == 2'd1) begin
            m_rts = reg_wdata[7]; m_dtr = reg_wdata[6];
            m_echo = reg_wdata[2]; m_test = reg_wdata[1];
         end
         if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[7:5];
         hist.push_front(newest);
         void'(hist.pop_back());
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic [7:0] exp_rd;
      string      rq;
      #1;
      if (!finished) begin
         case (reg_addr)
            2'd0: begin exp_rd = {m_flag, hist[1], 2'b00}; rq = "R2 R3 R4 R5"; end
            2'd1: begin exp_rd = {m_rts, m_dtr, 3'b000, m_echo, m_test, 1'b0}; rq = "R6"; end
            2'd2: begin exp_rd = {m_en, 5'b00000}; rq = "R7"; end
            default: begin exp_rd = 8'h00; rq = "R7"; end
         endcase
         check(rq, "reg_rdata", reg_rdata, exp_rd);
         check("R6", "rts_out", rts_out, m_rts);
         check("R6", "dtr_out", dtr_out, m_dtr);
         check("R8", "irq", irq, |(m_flag & m_en));
         check("R9 R10 R11", "line_tx_pin", line_tx_pin,
               m_test ? 1 : (m_echo ? line_rx_pin : core_tx_bit));
         check("R9 R10 R11", "core_rx_bit", core_rx_bit,
               m_test ? core_tx_bit : line_rx_pin);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #20000000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int lfsr = 32'h1ACE5;
      idle(3);
      // R1: reset state, read every address
      for (int a = 0; a < 4; a++) begin
         @(negedge clk); reg_addr = a[1:0];
         #1; check("R1", "reset rdata", reg_rdata, 0);
      end
      check("R1", "reset irq", irq, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      // R6: handshake outputs and readback
      wr(2'd1, 8'hFF); reg_addr = 2'd1; idle(2);
      wr(2'd1, 8'h40); idle(2);
      wr(2'd1, 8'h80); idle(2);
      // R2 R3: level and flag on CTS with interrupts off (R8)
      reg_addr = 2'd0;
      cts_in = 1'b1; idle(5);
      dsr_in = 1'b1; dcd_in = 1'b1; idle(5);
      // R7 R8: enable register and interrupt
      wr(2'd2, 8'hFF); reg_addr = 2'd2; idle(2);
      reg_addr = 2'd3; idle(1);
      // R4: zeros do not clear, level bits not writable; ones clear
      wr(2'd0, 8'h1F); reg_addr = 2'd0; idle(2);
      wr(2'd0, 8'h80); idle(2);
      wr(2'd0, 8'h60); idle(2);
      // R5: clear at several offsets from a line change
      for (int off = 0; off < 5; off++) begin
         @(negedge clk); dsr_in = ~dsr_in;
         idle(off);
         wr(2'd0, 8'hE0);
         reg_addr = 2'd0; idle(4);
         wr(2'd0, 8'hE0); idle(1);
      end
      // R9 R10 R11: loop modes
      for (int m = 0; m < 4; m++) begin
         wr(2'd1, {6'b000000, m[1:0]} << 1);
         for (int k = 0; k < 4; k++) begin
            @(negedge clk); line_rx_pin = k[0]; core_tx_bit = k[1];
         end
      end
      // random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 32'h1 : 32'h0);
         reg_wr = 1'b0;
         if (lfsr[3:0] == 4'd0) cts_in = ~cts_in;
         if (lfsr[7:4] == 4'd1) dsr_in = ~dsr_in;
         if (lfsr[11:8] == 4'd2) dcd_in = ~dcd_in;
         line_rx_pin = lfsr[12];
         core_tx_bit = lfsr[13];
         reg_addr = lfsr[15:14];
         if (lfsr[19:16] == 4'd5) begin
            reg_wr = 1'b1;
            reg_wdata = lfsr[27:20];
         end
      end
      @(negedge clk); reg_wr = 1'b0;
      idle(4);
      finish_run();
   end
endmodule